// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the sequence of column addresses for one SDRAM burst. A load strobe registers a start column together with a burst length code and an ordering select. After that, each advance pulse steps to the next beat of the burst. The generated column stays inside the aligned block of the burst length and wraps around within it. The order is either sequential (add the beat index) or interleaved (XOR the beat index).

A full-page burst walks the whole 256-column row sequentially and wraps at the row boundary. It has no final beat, so it runs until it is stopped. A new load may arrive on any cycle and replaces the burst in progress. A terminate strobe, raised for a burst-stop or a precharge, ends the burst early. A memory controller uses the column, valid and last-beat outputs to sequence column commands. Mode register decoding, the command bus and data movement belong to other blocks.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `valid_o` and `last_o` are 0.
- R2: The cycle after `load_i` is high, `valid_o` is 1 and `col_o` equals the loaded start column with beat index 0. A load during an active burst discards that burst and restarts from the new column.
- R3: Length codes on `len_code_i` are 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8 and 7 for full page. Codes 4, 5 and 6 behave as 1 beat. For N-beat bursts, the column bits above the low log2(N) bits stay at their start value.
- R4: With `ilv_i` = 0 at load, the low log2(N) column bits at beat k equal (start + k) mod N.
- R5: With `ilv_i` = 1 at load and a length of 2, 4 or 8, the low log2(N) column bits at beat k equal start XOR k.
- R6: A full-page burst gives column (start + k) mod 256 regardless of `ilv_i`. It never raises `last_o` and stays valid until a terminate or a new load.
- R7: `last_o` is 1 exactly on beat N-1 of a non-full-page burst. An advance on that beat ends the burst, so `valid_o` is 0 on the next cycle.
- R8: `term_i` without `load_i` makes `valid_o` 0 on the next cycle. When `load_i` and `term_i` are high together, the load wins.
- R9: With `adv_i` low and no load or terminate, `valid_o` and `col_o` hold their values.
- R10: Length code and ordering are captured at load. Changes on `len_code_i` or `ilv_i` during a burst have no effect on the column sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start a burst at `start_col_i` |
| start_col_i | input | 8 | Start column |
| len_code_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| adv_i | input | 1 | Step to the next beat |
| term_i | input | 1 | Stop the burst early |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | A burst is active and `col_o` is meaningful |
| last_o | output | 1 | Current beat is the final beat |

## Verification
Load, terminate and the advance on a final beat can all land in the same cycle. That cycle decides whether the next cycle shows a fresh burst or an idle generator. The bench places a load on the same cycle as a terminate, and another load on the cycle where `last_o` and `adv_i` are both high. It also drives all three strobes at random and dense enough that they often coincide. A behavioural model applies load over terminate over advance and is compared with the outputs on every clock.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
   typedef enum logic [2:0] {
      BLEN_1    = 3'd0,
      BLEN_2    = 3'd1,
      BLEN_4    = 3'd2,
      BLEN_8    = 3'd3,
      BLEN_PAGE = 3'd7
   } blen_code_e;

   localparam int unsigned LEN_CODE_W = 3;
   localparam int unsigned MAX_FIXED_LOG2 = 3;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_col_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [LEN_CODE_W-1:0] code_i,
   output logic [COL_W-1:0]      mask_o,
   output logic                  full_o
);
   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   always_comb begin
      mask_o = '0;
      full_o = 1'b0;
      case (code_i)
         BLEN_2:    mask_o = ONE;
         BLEN_4:    mask_o = (ONE << 2) - ONE;
         BLEN_8:    mask_o = (ONE << 3) - ONE;
         BLEN_PAGE: begin
            mask_o = '1;
            full_o = 1'b1;
         end
         default:   mask_o = '0;
      endcase
   end
endmodule

// File: rtl/burst_order_calc.sv
module burst_order_calc #(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] start_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   input  logic             full_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] sum;
   logic             use_xor;

   assign sum     = start_i + beat_i;
   assign use_xor = ilv_i & ~full_i;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      always_comb begin
         if (!mask_i[i])
            col_o[i] = start_i[i];
         else if (use_xor)
            col_o[i] = start_i[i] ^ beat_i[i];
         else
            col_o[i] = sum[i];
      end
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             term_i,
   input  logic             adv_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   output logic             valid_o,
   output logic             last_o,
   output logic [COL_W-1:0] beat_o
);
   logic valid_q;
   logic [COL_W-1:0] beat_q;

   assign last_o  = valid_q & ~full_i & (beat_q == mask_i);
   assign valid_o = valid_q;
   assign beat_o  = beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         beat_q  <= '0;
      end else if (load_i) begin
         valid_q <= 1'b1;
         beat_q  <= '0;
      end else if (term_i) begin
         valid_q <= 1'b0;
      end else if (valid_q && adv_i) begin
         if (last_o) valid_q <= 1'b0;
         else        beat_q  <= beat_q + COL_W'(1);
      end
   end

   AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && full_i) |-> !last_o); // R6
   AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_q); // R7
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import burst_col_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [COL_W-1:0]      start_col_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  ilv_i,
   input  logic                  adv_i,
   input  logic                  term_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  valid_o,
   output logic                  last_o
);
   if (COL_W < MAX_FIXED_LOG2) begin : g_bad_width
      $error("burst_col_gen: COL_W must cover the 8-beat block");
   end

   logic [COL_W-1:0] dec_mask;
   logic             dec_full;
   logic [COL_W-1:0] start_q, mask_q, beat;
   logic             full_q, ilv_q;

   burst_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i(len_code_i), .mask_o(dec_mask), .full_o(dec_full));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         mask_q  <= '0;
         full_q  <= 1'b0;
         ilv_q   <= 1'b0;
      end else if (load_i) begin
         start_q <= start_col_i;
         mask_q  <= dec_mask;
         full_q  <= dec_full;
         ilv_q   <= ilv_i;
      end
   end

   burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .term_i(term_i),
      .adv_i(adv_i), .mask_i(mask_q), .full_i(full_q),
      .valid_o(valid_o), .last_o(last_o), .beat_o(beat));

   burst_order_calc #(.COL_W(COL_W)) u_ord (
      .start_i(start_q), .beat_i(beat), .mask_i(mask_q),
      .ilv_i(ilv_q), .full_i(full_q), .col_o(col_o));

   AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (valid_o && col_o == $past(start_col_i))); // R2
   AST_TERM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (term_i && !load_i) |=> !valid_o); // R8
   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && adv_i && !load_i && !term_i) |=> !valid_o); // R7
   AST_HOLD_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !adv_i && !load_i && !term_i) |=> (valid_o && $stable(col_o))); // R9
endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_i = 1'b0, ilv_i = 1'b0, adv_i = 1'b0, term_i = 1'b0;
   logic [7:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic [7:0] col_o;
   logic       valid_o, last_o;

   int vectors = 0, errors = 0;
   string tag = "R1";

   // reference model state
   bit m_valid = 0, m_full = 0, m_ilv = 0;
   int m_start = 0, m_beat = 0, m_n = 1;

   always #4 clk = ~clk;

   burst_col_gen u_dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .ilv_i(ilv_i), .adv_i(adv_i), .term_i(term_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o));

   function automatic int code_len(input int c);
      case (c)
         1: return 2;
         2: return 4;
         3: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col();
      int off;
      if (m_full) return (m_start + m_beat) % 256;
      off = m_start % m_n;
      if (m_ilv) return (m_start - off) + (off ^ m_beat);
      return (m_start - off) + ((off + m_beat) % m_n);
   endfunction

   function automatic bit exp_last();
      return m_valid && !m_full && (m_beat == m_n - 1);
   endfunction

   task automatic compare();
      vectors++;
      if (valid_o !== m_valid) begin
         errors++;
         $display("FAIL %s valid_o actual=%0b expected=%0b", tag, valid_o, m_valid);
      end else if (last_o !== exp_last()) begin
         errors++;
         $display("FAIL %s last_o actual=%0b expected=%0b", tag, last_o, exp_last());
      end else if (m_valid && int'(col_o) != exp_col()) begin
         errors++;
         $display("FAIL %s col_o actual=%0d expected=%0d", tag, col_o, exp_col());
      end
   endtask

   task automatic model_step();
      if (!rst_n) m_valid = 0;
      else if (load_i) begin
         m_valid = 1; m_start = int'(start_col_i); m_beat = 0;
         m_full = (len_code_i == 3'd7); m_n = code_len(int'(len_code_i));
         m_ilv = ilv_i;
      end else if (term_i) m_valid = 0;
      else if (m_valid && adv_i) begin
         if (exp_last()) m_valid = 0;
         else m_beat = (m_beat + 1) % 256;
      end
   endtask

   // one clock: check outputs, then drive inputs for the next edge
   task automatic cyc(input bit l, input int st, input int code, input bit il,
                      input bit a, input bit t);
      @(negedge clk);
      compare();
      load_i = l; start_col_i = 8'(st); len_code_i = 3'(code); ilv_i = il;
      adv_i = a; term_i = t;
      model_step();
   endtask

   task automatic run(input int n, input bit a);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, a, 0);
   endtask

   initial begin : watchdog
      #1600000;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      tag = "R1";
      rst_n = 1'b0;
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0);
      @(negedge clk); rst_n = 1'b1;
      run(2, 1);
      tag = "R4"; // sequential, lengths 2/4/8 from unaligned starts
      cyc(1, 8'h35, 1, 0, 0, 0); run(3, 1);
      cyc(1, 8'h4E, 2, 0, 0, 0); run(5, 1);
      cyc(1, 8'hA5, 3, 0, 0, 0); run(9, 1);
      tag = "R5"; // interleaved
      cyc(1, 8'h4E, 2, 1, 0, 0); run(5, 1);
      cyc(1, 8'h13, 3, 1, 0, 0); run(9, 1);
      cyc(1, 8'hFF, 1, 1, 0, 0); run(3, 1);
      tag = "R3"; // length 1 and reserved codes 4..6
      for (int c = 4; c < 7; c++) begin
         cyc(1, 8'h70 + c, c, 0, 0, 0); run(2, 1);
      end
      cyc(1, 8'h33, 0, 1, 0, 0); run(2, 1);
      tag = "R6"; // full page wraps at the row end, ilv ignored
      cyc(1, 8'hFA, 7, 1, 0, 0); run(12, 1);
      cyc(1, 8'h01, 7, 0, 0, 0); run(300, 1);
      cyc(0, 0, 0, 0, 1, 1); run(2, 1);
      tag = "R9"; // hold with adv low
      cyc(1, 8'h21, 3, 0, 0, 0); run(4, 0); run(3, 1); run(3, 0); run(6, 1);
      tag = "R8"; // terminate mid burst, and load beating terminate
      cyc(1, 8'h80, 3, 0, 0, 0); run(2, 1); cyc(0, 0, 0, 0, 1, 1); run(3, 1);
      cyc(1, 8'h90, 2, 0, 0, 0); cyc(1, 8'hC7, 3, 1, 1, 1); run(9, 1);
      tag = "R7"; // load on the final beat with advance
      cyc(1, 8'h02, 1, 0, 0, 0); cyc(0, 0, 0, 0, 1, 0);
      cyc(1, 8'h55, 2, 1, 1, 0); run(5, 1);
      tag = "R2"; // reload mid burst
      cyc(1, 8'h10, 3, 0, 0, 0); run(3, 1); cyc(1, 8'hE9, 2, 0, 1, 0); run(5, 1);
      tag = "R10"; // inputs change mid burst
      cyc(1, 8'h0B, 3, 1, 0, 0);
      for (int i = 0; i < 9; i++) cyc(0, i * 7, 7 - (i % 8), i[0], 1, 0);
      tag = "R10"; // random mix, dense coincidences
      for (int i = 0; i < 4000; i++)
         cyc(($urandom % 10) == 0, int'($urandom % 256), int'($urandom % 8),
             1'($urandom), ($urandom % 4) != 0, ($urandom % 25) == 0);
      run(2, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule